// File: doc/BRIEF.md
# Sleep and Power-Off Sequencer

This block decides which clocks of a small 8-bit controller run and when. Software first writes a three-bit sleep code. It then sets a sleep-enable bit and issues a one-cycle sleep strobe. The block responds by gating the core clock, the I/O and converter clocks, and a vector of per-peripheral clocks. From the deepest state it can also ask the supply regulator to shut down. Three sleep states exist: a light idle state, a power-save state, and a power-off state.

Wake-up has two sources: a level-sensitive external request and a charger-detect event. The level request is filtered, so a short glitch cannot wake the core. Leaving power-save passes through a programmable start-up wait, so the oscillator can settle before the core clock returns. Power-off can be left only on a charger-detect event, and it ends in a one-cycle reset request rather than in resumed execution.

A power-reduction register holds one stop bit per peripheral. Each set bit freezes that peripheral's clock, and with it the peripheral's state and register access, while the core runs. All pins are plain control and status levels or strobes. No data stream crosses the block's edge, so it has no valid/ready handshake.

Top module: `sleep_pwr_ctrl`

## Requirements
- R1: After reset the block is active. The core, I/O and converter clock enables are 1, every peripheral enable is 1, the regulator-off and reset requests are 0, and the watchdog run output equals the watchdog enable input.
- R2: A sleep strobe with sleep enable high, taken while active, acts on the stored sleep code. Code 3'b000 selects idle, code 3'b011 selects power-save, and code 3'b100 selects power-off (subject to R3). Any other code, or a low sleep enable, leaves the block active. A strobe in the same cycle as a code write uses the previously stored code.
- R3: Power-off is entered only if the strobe comes 1 to 4 cycles after the cycle of the code write. A later strobe with code 3'b100 leaves the block active. An interrupt-pending pulse in the cycle of the strobe, or in any cycle after the write and before the strobe, closes the window, and the block stays active.
- R4: In idle the core clock enable is 0, and the I/O and converter enables stay 1. The cycle after an accepted wake (R7) or a charger-detect pulse, the block is active again.
- R5: In power-save the core, I/O and converter enables are 0. The watchdog keeps running if it is enabled.
- R6: A wake from power-save keeps the core clock off for su_delay+1 cycles after the wake edge, with the I/O clock still off. The core clock then returns.
- R7: The external level request counts as a wake only once it has been high for HOLD consecutive sampled cycles (default 3). Shorter pulses have no effect.
- R8: In power-off the regulator-off request is 1, and every clock enable and the watchdog run output are 0. Only charger detect ends it; the external request is ignored.
- R9: A charger-detect pulse in power-off gives exactly one cycle with the reset request 1. The block is active in the next cycle, with the power-reduction register cleared (all peripheral enables 1).
- R10: The watchdog run output is 1 exactly when the watchdog enable is 1 and the block is not in power-off.
- R11: While active or idle, peripheral enable bit i equals the inverse of power-reduction bit i. A register write shows at the outputs in the cycle after it is taken. The register keeps its contents across every sleep state except power-off.
- R12: In power-save, during the start-up wait and in power-off, every peripheral enable is 0, whatever the register holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Strobe storing mode_in as the sleep code |
| mode_in | input | 3 | Sleep code to store |
| sleep_en | input | 1 | Sleep enable bit |
| sleep_cmd | input | 1 | One-cycle sleep strobe from the core |
| irq_pending | input | 1 | Interrupt pending; closes the power-off window |
| ext_wake | input | 1 | Level-sensitive external wake request |
| chg_det | input | 1 | Charger-detect event |
| su_delay | input | SU_W | Start-up wait after a power-save wake, in cycles minus one |
| wdt_en | input | 1 | Watchdog enable |
| prr_wr | input | 1 | Strobe loading the power-reduction register |
| prr_in | input | NP | New power-reduction bits, one per peripheral |
| cpu_clk_en | output | 1 | Core clock enable |
| io_clk_en | output | 1 | I/O clock enable |
| adc_clk_en | output | 1 | Converter clock enable |
| periph_clk_en | output | NP | Per-peripheral clock enables |
| reg_off_req | output | 1 | Regulator shutdown request |
| wdt_run | output | 1 | Watchdog run enable |
| rst_req | output | 1 | One-cycle reset request on leaving power-off |

## Verification
Two pairs of events can fall in the same cycle. The first is a sleep-code write and the sleep strobe: the sweep puts the strobe zero to six cycles after the write for all eight codes and both enable values, and the zero-cycle case must act on the earlier code 3'b111, which does nothing. The second is an interrupt-pending pulse and the strobe, which must block power-off, just as a pulse in an earlier cycle of the window does. The expected state comes from the code, the distance in cycles and the enable bit, and is judged on the clock enables and the regulator request one cycle after the strobe.

// File: rtl/sleep_pkg.sv
package sleep_pkg;
  typedef enum logic [2:0] {
    ST_ACT   = 3'd0,
    ST_IDLE  = 3'd1,
    ST_PSAVE = 3'd2,
    ST_PWAKE = 3'd3,
    ST_POFF  = 3'd4,
    ST_PRST  = 3'd5
  } pwr_state_t;

  localparam logic [2:0] CODE_IDLE  = 3'b000;
  localparam logic [2:0] CODE_PSAVE = 3'b011;
  localparam logic [2:0] CODE_POFF  = 3'b100;
endpackage

// File: rtl/sleep_window.sv
module sleep_window #(
  parameter int WIN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_wr,
  input  logic irq_pending,
  output logic win_open
);
  localparam int CW = $clog2(WIN + 1);
  localparam logic [CW-1:0] START = CW'(WIN);

  logic [CW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left <= '0;
    end else if (mode_wr) begin
      left <= START;
    end else if (irq_pending) begin
      left <= '0;
    end else if (left != '0) begin
      left <= left - 1'b1;
    end
  end

  assign win_open = (left != '0) && !irq_pending;
endmodule

// File: rtl/wake_filter.sv
module wake_filter #(
  parameter int HOLD = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic accept
);
  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] SAT  = CW'(HOLD);
  localparam logic [CW-1:0] NEED = CW'(HOLD - 1);

  logic [CW-1:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen <= '0;
    end else if (!lvl) begin
      seen <= '0;
    end else if (seen != SAT) begin
      seen <= seen + 1'b1;
    end
  end

  assign accept = lvl && (seen >= NEED);
endmodule

// File: rtl/power_fsm.sv
module power_fsm
  import sleep_pkg::*;
#(
  parameter int SU_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sleep_cmd,
  input  logic            sleep_en,
  input  logic [2:0]      code,
  input  logic            win_open,
  input  logic            ext_ok,
  input  logic            chg_det,
  input  logic [SU_W-1:0] su_delay,
  output pwr_state_t      state
);
  pwr_state_t      nxt;
  logic [SU_W-1:0] su_cnt;
  logic            go_sleep;

  assign go_sleep = sleep_cmd && sleep_en;

  always_comb begin
    nxt = state;
    case (state)
      ST_ACT: begin
        if (go_sleep) begin
          if (code == CODE_IDLE)                 nxt = ST_IDLE;
          else if (code == CODE_PSAVE)           nxt = ST_PSAVE;
          else if (code == CODE_POFF && win_open) nxt = ST_POFF;
        end
      end
      ST_IDLE:  if (ext_ok || chg_det) nxt = ST_ACT;
      ST_PSAVE: if (ext_ok || chg_det) nxt = ST_PWAKE;
      ST_PWAKE: if (su_cnt == '0)      nxt = ST_ACT;
      ST_POFF:  if (chg_det)           nxt = ST_PRST;
      ST_PRST:                         nxt = ST_ACT;
      default:                         nxt = ST_ACT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_ACT;
      su_cnt <= '0;
    end else begin
      state <= nxt;
      if (state == ST_PSAVE && nxt == ST_PWAKE) begin
        su_cnt <= su_delay;
      end else if (state == ST_PWAKE && su_cnt != '0) begin
        su_cnt <= su_cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/clk_gate_dec.sv
module clk_gate_dec
  import sleep_pkg::*;
#(
  parameter int NP = 4
) (
  input  pwr_state_t    state,
  input  logic [NP-1:0] prr,
  input  logic          wdt_en,
  output logic          cpu_clk_en,
  output logic          io_clk_en,
  output logic          adc_clk_en,
  output logic [NP-1:0] periph_clk_en,
  output logic          reg_off_req,
  output logic          wdt_run,
  output logic          rst_req
);
  logic bus_live;

  assign bus_live    = (state == ST_ACT) || (state == ST_IDLE);
  assign cpu_clk_en  = (state == ST_ACT);
  assign io_clk_en   = bus_live;
  assign adc_clk_en  = bus_live;
  assign reg_off_req = (state == ST_POFF);
  assign rst_req     = (state == ST_PRST);
  assign wdt_run     = wdt_en && (state != ST_POFF);

  for (genvar i = 0; i < NP; i++) begin : g_periph
    assign periph_clk_en[i] = bus_live && !prr[i];
  end
endmodule

// File: rtl/sleep_pwr_ctrl.sv
module sleep_pwr_ctrl
  import sleep_pkg::*;
#(
  parameter int NP   = 4,
  parameter int HOLD = 3,
  parameter int WIN  = 4,
  parameter int SU_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_wr,
  input  logic [2:0]      mode_in,
  input  logic            sleep_en,
  input  logic            sleep_cmd,
  input  logic            irq_pending,
  input  logic            ext_wake,
  input  logic            chg_det,
  input  logic [SU_W-1:0] su_delay,
  input  logic            wdt_en,
  input  logic            prr_wr,
  input  logic [NP-1:0]   prr_in,
  output logic            cpu_clk_en,
  output logic            io_clk_en,
  output logic            adc_clk_en,
  output logic [NP-1:0]   periph_clk_en,
  output logic            reg_off_req,
  output logic            wdt_run,
  output logic            rst_req
);
  logic [2:0]    code_q;
  logic [NP-1:0] prr_q;
  logic          win_open;
  logic          ext_ok;
  pwr_state_t    state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= CODE_IDLE;
    end else if (mode_wr) begin
      code_q <= mode_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prr_q <= '0;
    end else if (state == ST_PRST) begin
      prr_q <= '0;
    end else if (prr_wr) begin
      prr_q <= prr_in;
    end
  end

  sleep_window #(.WIN(WIN)) u_win (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr),
    .irq_pending(irq_pending), .win_open(win_open)
  );

  wake_filter #(.HOLD(HOLD)) u_filt (
    .clk(clk), .rst_n(rst_n), .lvl(ext_wake), .accept(ext_ok)
  );

  power_fsm #(.SU_W(SU_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sleep_cmd(sleep_cmd), .sleep_en(sleep_en),
    .code(code_q), .win_open(win_open), .ext_ok(ext_ok), .chg_det(chg_det),
    .su_delay(su_delay), .state(state)
  );

  clk_gate_dec #(.NP(NP)) u_dec (
    .state(state), .prr(prr_q), .wdt_en(wdt_en),
    .cpu_clk_en(cpu_clk_en), .io_clk_en(io_clk_en), .adc_clk_en(adc_clk_en),
    .periph_clk_en(periph_clk_en), .reg_off_req(reg_off_req),
    .wdt_run(wdt_run), .rst_req(rst_req)
  );
endmodule

// File: rtl/sleep_pwr_ctrl_chk.sv
module sleep_pwr_ctrl_chk #(
  parameter int NP   = 4,
  parameter int HOLD = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode_wr,
  input logic          sleep_en,
  input logic          sleep_cmd,
  input logic          irq_pending,
  input logic          ext_wake,
  input logic          chg_det,
  input logic          wdt_en,
  input logic          cpu_clk_en,
  input logic          io_clk_en,
  input logic          adc_clk_en,
  input logic [NP-1:0] periph_clk_en,
  input logic          reg_off_req,
  input logic          wdt_run,
  input logic          rst_req
);
  logic [2:0] since;
  logic [7:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since <= 3'd7;
      run   <= '0;
    end else begin
      if (mode_wr)            since <= 3'd1;
      else if (since != 3'd7) since <= since + 3'd1;
      if (!ext_wake)          run <= '0;
      else if (run != 8'hFF)  run <= run + 8'd1;
    end
  end

  assert_stay_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && !(sleep_cmd && sleep_en)) |=> cpu_clk_en);

  assert_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_off_req) |-> $past(sleep_cmd && sleep_en && !irq_pending &&
                                 since >= 3'd1 && since <= 3'd4));

  assert_core_implies_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en |-> (io_clk_en && adc_clk_en));

  assert_idle_wake_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cpu_clk_en) && $past(io_clk_en)) |->
      $past(chg_det || (ext_wake && run >= 8'(HOLD - 1))));

  assert_poff_gates_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_off_req |-> (!cpu_clk_en && !io_clk_en && !adc_clk_en &&
                     periph_clk_en == '0 && !wdt_run));

  assert_poff_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_off_req && !chg_det) |=> reg_off_req);

  assert_poff_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_off_req && chg_det) |=> (rst_req && !reg_off_req));

  assert_rst_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> (!rst_req && cpu_clk_en && (&periph_clk_en)));

  assert_wdt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_run == (wdt_en && !reg_off_req));
endmodule

bind sleep_pwr_ctrl sleep_pwr_ctrl_chk #(.NP(NP), .HOLD(HOLD)) u_chk (.*);

// File: tb/sleep_pwr_ctrl_test.sv
module sleep_pwr_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP   = 4;
  localparam int HOLD = 3;
  localparam int SU_W = 4;

  logic clk = 1'b0;
  logic rst_n, mode_wr, sleep_en, sleep_cmd, irq_pending, ext_wake, chg_det;
  logic wdt_en, prr_wr;
  logic [2:0] mode_in;
  logic [SU_W-1:0] su_delay;
  logic [NP-1:0] prr_in;
  logic cpu_clk_en, io_clk_en, adc_clk_en, reg_off_req, wdt_run, rst_req;
  logic [NP-1:0] periph_clk_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sleep_pwr_ctrl #(.NP(NP), .HOLD(HOLD), .WIN(4), .SU_W(SU_W)) uut (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_in(mode_in),
    .sleep_en(sleep_en), .sleep_cmd(sleep_cmd), .irq_pending(irq_pending),
    .ext_wake(ext_wake), .chg_det(chg_det), .su_delay(su_delay),
    .wdt_en(wdt_en), .prr_wr(prr_wr), .prr_in(prr_in),
    .cpu_clk_en(cpu_clk_en), .io_clk_en(io_clk_en), .adc_clk_en(adc_clk_en),
    .periph_clk_en(periph_clk_en), .reg_off_req(reg_off_req),
    .wdt_run(wdt_run), .rst_req(rst_req)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic go_active();
    ext_wake = 1'b0;
    chg_det = 1'b1;
    tick();
    chg_det = 1'b0;
    repeat (12) tick();
  endtask

  task automatic write_code(input logic [2:0] c);
    mode_wr = 1'b1;
    mode_in = c;
    tick();
    mode_wr = 1'b0;
  endtask

  task automatic enter_mode(input logic [2:0] c);
    write_code(c);
    sleep_en = 1'b1;
    sleep_cmd = 1'b1;
    tick();
    sleep_cmd = 1'b0;
  endtask

  task automatic load_prr(input logic [NP-1:0] v);
    prr_wr = 1'b1;
    prr_in = v;
    tick();
    prr_wr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode_wr = 1'b0; mode_in = 3'd0; sleep_en = 1'b0;
    sleep_cmd = 1'b0; irq_pending = 1'b0; ext_wake = 1'b0; chg_det = 1'b0;
    su_delay = 4'd2; wdt_en = 1'b1; prr_wr = 1'b0; prr_in = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1 cpu", int'(cpu_clk_en), 1);
    chk("R1 io", int'(io_clk_en), 1);
    chk("R1 adc", int'(adc_clk_en), 1);
    chk("R1 periph", int'(periph_clk_en), 15);
    chk("R1 regoff", int'(reg_off_req), 0);
    chk("R1 rstreq", int'(rst_req), 0);
    chk("R1 wdt", int'(wdt_run), 1);

    // R11 power-reduction sweep while active
    for (int v = 0; v < 16; v++) begin
      load_prr(NP'(v));
      chk($sformatf("R11 active prr=%0d", v), int'(periph_clk_en), (~v) & 15);
    end

    // R4 idle with power-reduction sweep
    load_prr('0);
    enter_mode(3'b000);
    chk("R4 idle cpu", int'(cpu_clk_en), 0);
    chk("R4 idle io", int'(io_clk_en), 1);
    chk("R4 idle adc", int'(adc_clk_en), 1);
    for (int v = 0; v < 16; v++) begin
      load_prr(NP'(v));
      chk($sformatf("R11 idle prr=%0d", v), int'(periph_clk_en), (~v) & 15);
    end
    chg_det = 1'b1;
    tick();
    chg_det = 1'b0;
    chk("R4 idle wake next cycle", int'(cpu_clk_en), 1);

    // R5 / R12 power-save
    load_prr('0);
    enter_mode(3'b011);
    chk("R5 psave cpu", int'(cpu_clk_en), 0);
    chk("R5 psave io", int'(io_clk_en), 0);
    chk("R5 psave adc", int'(adc_clk_en), 0);
    chk("R5 psave wdt", int'(wdt_run), 1);
    for (int v = 0; v < 16; v++) begin
      load_prr(NP'(v));
      chk($sformatf("R12 psave prr=%0d", v), int'(periph_clk_en), 0);
    end
    go_active();
    chk("R11 prr kept after psave", int'(periph_clk_en), 0);
    load_prr('0);
    chk("R11 prr cleared", int'(periph_clk_en), 15);

    // R2 / R3 sweep: code x strobe distance x enable
    for (int m = 0; m < 8; m++) begin
      for (int d = 0; d < 7; d++) begin
        for (int en = 0; en < 2; en++) begin
          int code;
          bit to_idle, to_ps, to_off;
          go_active();
          write_code(3'b111);
          repeat (6) tick();
          mode_wr = 1'b1;
          mode_in = 3'(m);
          if (d == 0) begin
            sleep_cmd = 1'b1;
            sleep_en = 1'(en);
          end
          tick();
          mode_wr = 1'b0;
          sleep_cmd = 1'b0;
          if (d > 0) begin
            repeat (d - 1) tick();
            sleep_cmd = 1'b1;
            sleep_en = 1'(en);
            tick();
            sleep_cmd = 1'b0;
          end
          code = (d == 0) ? 7 : m;
          to_idle = (en == 1) && (code == 0);
          to_ps   = (en == 1) && (code == 3);
          to_off  = (en == 1) && (code == 4) && (d >= 1) && (d <= 4);
          chk($sformatf("R2 R3 cpu m=%0d d=%0d en=%0d", m, d, en),
              int'(cpu_clk_en), int'(!(to_idle || to_ps || to_off)));
          chk($sformatf("R2 io m=%0d d=%0d en=%0d", m, d, en),
              int'(io_clk_en), int'(!(to_ps || to_off)));
          chk($sformatf("R3 regoff m=%0d d=%0d en=%0d", m, d, en),
              int'(reg_off_req), int'(to_off));
        end
      end
    end

    // R3 interrupt pending closes the window
    for (int k = 0; k < 3; k++) begin
      go_active();
      write_code(3'b100);
      sleep_en = 1'b1;
      irq_pending = (k == 1);
      tick();
      irq_pending = (k == 2);
      sleep_cmd = 1'b1;
      tick();
      sleep_cmd = 1'b0;
      irq_pending = 1'b0;
      chk($sformatf("R3 irq case %0d regoff", k), int'(reg_off_req), int'(k == 0));
    end

    // R7 level filter widths
    for (int w = 1; w <= HOLD + 2; w++) begin
      go_active();
      enter_mode(3'b000);
      ext_wake = 1'b1;
      repeat (w) tick();
      chk($sformatf("R7 pulse w=%0d", w), int'(cpu_clk_en), int'(w >= HOLD));
      ext_wake = 1'b0;
      repeat (2) tick();
      chk($sformatf("R7 after pulse w=%0d", w), int'(cpu_clk_en), int'(w >= HOLD));
    end

    // R6 start-up wait sweep
    for (int dl = 0; dl < 8; dl++) begin
      int cnt;
      go_active();
      su_delay = SU_W'(dl);
      enter_mode(3'b011);
      chg_det = 1'b1;
      tick();
      chg_det = 1'b0;
      chk($sformatf("R12 startup io dl=%0d", dl), int'(io_clk_en), 0);
      cnt = 0;
      while (!cpu_clk_en && cnt < 40) begin
        cnt++;
        tick();
      end
      chk($sformatf("R6 startup dl=%0d", dl), cnt, dl + 1);
    end
    su_delay = 4'd2;

    // R8 / R9 / R10 power-off
    go_active();
    load_prr(4'b0101);
    enter_mode(3'b100);
    chk("R8 regoff", int'(reg_off_req), 1);
    chk("R8 cpu", int'(cpu_clk_en), 0);
    chk("R12 poff periph", int'(periph_clk_en), 0);
    chk("R10 wdt off in poff", int'(wdt_run), 0);
    ext_wake = 1'b1;
    repeat (HOLD + 3) tick();
    ext_wake = 1'b0;
    tick();
    chk("R8 ext ignored", int'(reg_off_req), 1);
    chg_det = 1'b1;
    tick();
    chg_det = 1'b0;
    chk("R9 rst pulse", int'(rst_req), 1);
    chk("R9 cpu during rst", int'(cpu_clk_en), 0);
    tick();
    chk("R9 rst ends", int'(rst_req), 0);
    chk("R9 active after", int'(cpu_clk_en), 1);
    chk("R9 prr cleared", int'(periph_clk_en), 15);

    // R10 watchdog disabled
    wdt_en = 1'b0;
    tick();
    chk("R10 wdt disabled active", int'(wdt_run), 0);
    enter_mode(3'b011);
    chk("R10 wdt disabled psave", int'(wdt_run), 0);
    wdt_en = 1'b1;
    tick();
    chk("R10 wdt enabled psave", int'(wdt_run), 1);
    go_active();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule